// File: doc/BRIEF.md
# Condition Code Pass Evaluator

This block decides whether a conditionally executed instruction is allowed to take effect, given the arithmetic status flags of the moment. It accepts either a 32-bit instruction word, where the 4-bit condition code sits in the top nibble and governs every instruction, or a 16-bit instruction word, where only the conditional-branch pattern (top nibble equal to 4'hD) carries a condition code, located in bits 11:8.

The negative, zero, carry and overflow flags are taken from fixed positions of a 32-bit status word. One clock after the inputs are presented, the block gives a registered pass decision and a flag that marks a 16-bit conditional branch. A front-end step unit uses these outputs to choose between executing the instruction and skipping to the next one.

Top module: `cond_pass_eval`

## Requirements
- R1: Flags are read from the status word at N = bit 31, Z = bit 30, C = bit 29, V = bit 28. No other status bit affects any output.
- R2: Codes 0 through 7 pass on, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R5: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R6: Codes 14 and 15 always pass.
- R7: When fmt_short=0, the code is insn_word[31:28] and it is evaluated for every word. cond_branch_o is 0.
- R8: When fmt_short=1 and insn_word[15:12]=4'hD, the code is insn_word[11:8] and cond_branch_o is 1.
- R9: When fmt_short=1 and insn_word[15:12] is not 4'hD, pass_o is 1 and cond_branch_o is 0, whatever the flags are. In the short format, insn_word[31:16] is ignored.
- R10: Both outputs are registered and reflect the inputs sampled at the previous rising clock edge. While rst is high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_short | input | 1 | 1 selects the 16-bit format, 0 selects the 32-bit format |
| insn_word | input | 32 | Instruction word. The 16-bit format uses bits 15:0 |
| status_word | input | 32 | Status word holding N, Z, C and V |
| pass_o | output | 1 | Registered execute decision |
| cond_branch_o | output | 1 | Registered indication of a 16-bit conditional branch |

## Verification
On every cycle, the assertions check three things: the short-format gating (a plain 16-bit word always passes and is never marked as a branch), the branch marking, and the always-pass codes and the carry-and-not-zero code. Each is checked against the inputs of the previous cycle. The bench's scenarios are the only check on the full truth table of all sixteen codes under all sixteen flag combinations, in both formats. They also show that the status bits outside the four flags and the upper half of a short word have no effect, and that a reset mid-run clears the outputs.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int CODE_W = 4;
  localparam int NCODES = 1 << CODE_W;
  localparam int SHORT_W = 16;
  localparam logic [3:0] SHORT_BR_PAT = 4'hD;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cpe_flag_tap.sv
module cpe_flag_tap
  import cpe_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int N_POS  = 31,
  parameter int Z_POS  = 30,
  parameter int C_POS  = 29,
  parameter int V_POS  = 28
) (
  input  logic [STAT_W-1:0] status,
  output flags_t            flags
);
  assign flags.n = status[N_POS];
  assign flags.z = status[Z_POS];
  assign flags.c = status[C_POS];
  assign flags.v = status[V_POS];
endmodule

// File: rtl/cpe_field_pick.sv
module cpe_field_pick
  import cpe_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              is_short,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic              gated,
  output logic              short_br
);
  localparam int LONG_HI = WORD_W - 1;
  logic br_match;

  assign br_match = (word[SHORT_W-1 -: 4] == SHORT_BR_PAT);

  always_comb begin
    if (is_short) begin
      code     = word[SHORT_W-5 -: CODE_W];
      gated    = br_match;
      short_br = br_match;
    end else begin
      code     = word[LONG_HI -: CODE_W];
      gated    = 1'b1;
      short_br = 1'b0;
    end
  end
endmodule

// File: rtl/cpe_code_table.sv
module cpe_code_table
  import cpe_pkg::*;
(
  input  flags_t            flags,
  output logic [NCODES-1:0] table_o
);
  localparam int NPAIRS = NCODES / 2;
  logic [NPAIRS-1:0] base;
  logic n_eq_v;

  assign n_eq_v = (flags.n == flags.v);

  always_comb begin
    base[0] = flags.z;
    base[1] = flags.c;
    base[2] = flags.n;
    base[3] = flags.v;
    base[4] = flags.c & ~flags.z;
    base[5] = n_eq_v;
    base[6] = ~flags.z & n_eq_v;
    base[7] = 1'b1;
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign table_o[2*p] = base[p];
    if (p == NPAIRS - 1) begin : g_always
      assign table_o[2*p+1] = 1'b1;
    end else begin : g_inverse
      assign table_o[2*p+1] = ~base[p];
    end
  end
endmodule

// File: rtl/cond_pass_eval.sv
module cond_pass_eval
  import cpe_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STAT_W = 32,
  parameter int N_POS  = 31,
  parameter int Z_POS  = 30,
  parameter int C_POS  = 29,
  parameter int V_POS  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fmt_short,
  input  logic [WORD_W-1:0] insn_word,
  input  logic [STAT_W-1:0] status_word,
  output logic              pass_o,
  output logic              cond_branch_o
);
  flags_t            flg;
  logic [CODE_W-1:0] code;
  logic              gated;
  logic              short_br;
  logic [NCODES-1:0] tbl;
  logic              pass_d;

  cpe_flag_tap #(
    .STAT_W(STAT_W), .N_POS(N_POS), .Z_POS(Z_POS), .C_POS(C_POS), .V_POS(V_POS)
  ) u_tap (
    .status(status_word),
    .flags (flg)
  );

  cpe_field_pick #(.WORD_W(WORD_W)) u_pick (
    .is_short(fmt_short),
    .word    (insn_word),
    .code    (code),
    .gated   (gated),
    .short_br(short_br)
  );

  cpe_code_table u_tbl (
    .flags  (flg),
    .table_o(tbl)
  );

  assign pass_d = gated ? tbl[code] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_o        <= 1'b0;
      cond_branch_o <= 1'b0;
    end else begin
      pass_o        <= pass_d;
      cond_branch_o <= short_br;
    end
  end

  // R9: plain short word always passes, never flagged
  a_r9_plain_short_passes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fmt_short) && ($past(insn_word[15:12]) != 4'hD))
      |-> (pass_o && !cond_branch_o));

  // R8, R7: branch flag only after short conditional-branch words
  a_r8_branch_flag_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cond_branch_o) |-> ($past(fmt_short) && ($past(insn_word[15:12]) == 4'hD)));

  // R6: codes 14 and 15 in long format always pass
  a_r6_always_codes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fmt_short) && ($past(insn_word[WORD_W-1 -: 3]) == 3'b111))
      |-> pass_o);

  // R3: code 8 with C set and Z clear passes
  a_r3_carry_not_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fmt_short) && ($past(insn_word[WORD_W-1 -: 4]) == 4'd8)
      && $past(status_word[C_POS]) && !$past(status_word[Z_POS]))
      |-> pass_o);
endmodule

// File: tb/cond_pass_eval_test.sv
`timescale 1ns/1ps
module cond_pass_eval_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_short = 1'b0;
  logic [31:0] insn_word = '0;
  logic [31:0] status_word = '0;
  logic        pass_o, cond_branch_o;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cond_pass_eval uut (
    .clk(clk), .rst(rst), .fmt_short(fmt_short), .insn_word(insn_word),
    .status_word(status_word), .pass_o(pass_o), .cond_branch_o(cond_branch_o)
  );

  function automatic bit ref_code(input int cd, input bit n, z, c, v);
    case (cd)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c && !z;  9: return !c || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input int cd);
    if (cd < 8) return "R2";
    if (cd < 10) return "R3";
    if (cd < 12) return "R4";
    if (cd < 14) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input bit ep, input bit eb);
    applied++;
    if (pass_o !== ep || cond_branch_o !== eb) begin
      bad++;
      $display("FAIL %s: got pass=%b br=%b, expected pass=%b br=%b",
               req, pass_o, cond_branch_o, ep, eb);
    end
  endtask

  // drive at negedge, compare at next negedge (one register stage)
  task automatic apply(input bit sh, input logic [31:0] w, input logic [31:0] st,
                       input string req);
    bit ep, eb;
    int cd;
    bit n, z, c, v;
    n = st[31]; z = st[30]; c = st[29]; v = st[28];
    if (!sh) begin
      cd = int'(w[31:28]); ep = ref_code(cd, n, z, c, v); eb = 0;
    end else if (w[15:12] == 4'hD) begin
      cd = int'(w[11:8]); ep = ref_code(cd, n, z, c, v); eb = 1;
    end else begin
      ep = 1; eb = 0;
    end
    fmt_short = sh; insn_word = w; status_word = st;
    @(negedge clk);
    check(req, ep, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 1'b0);            // reset state
    rst = 1'b0;
    // R7 with R2..R6: every code against every flag set, noise in other bits
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        apply(1'b0, {cd[3:0], 28'($urandom)}, {f[3:0], 28'($urandom)}, req_of(cd));
    // R8: short conditional branches, upper half random (ignored)
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        apply(1'b1, {16'($urandom), 4'hD, cd[3:0], 8'($urandom)},
              {f[3:0], 28'($urandom)}, "R8");
    // R9: short non-branch words, flags chosen so a condition would fail
    for (int t = 0; t < 16; t++) begin
      if (t == 13) continue;
      apply(1'b1, {16'hD0D0, t[3:0], 4'h0, 8'h00}, 32'h0000_0000, "R9");
      apply(1'b1, {16'h0000, t[3:0], 4'h1, 8'hFF}, 32'h4000_0000, "R9");
    end
    // R1: only bits 31:28 matter; fill the rest with ones and zeros
    apply(1'b0, 32'h0000_0000, 32'h0FFF_FFFF, "R1");   // Z clear -> code 0 fails
    apply(1'b0, 32'h1000_0000, 32'h4000_0000, "R1");   // Z set -> code 1 fails
    apply(1'b0, 32'h2000_0000, 32'hDFFF_FFFF, "R1");   // C clear -> code 2 fails
    apply(1'b0, 32'h6000_0000, 32'h1000_0000, "R1");   // V set -> code 6 passes
    // R10: reset mid-run clears outputs
    fmt_short = 1'b1; insn_word = 32'h0000_1234; rst = 1'b1;
    @(negedge clk);
    check("R10", 1'b0, 1'b0);
    rst = 1'b0;
    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 3 == 0) w[15:12] = 4'hD;
      apply(1'($urandom), w, $urandom, "R7");
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      applied++; bad++;
      $display("FAIL R10: watchdog expired, got running, expected finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule